// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the register file and host bus port of a dual-tone signalling transceiver. A small microprocessor reaches it over a 4-bit data bus, using a chip select, one register-select line, a read/write direction and a one-cycle access strobe. Four address and direction combinations give access to five registers. These are a write-only transmit digit register, a read-only receive digit register, two write-only control registers behind a single address, and a status register whose flags clear when it is read. The block also drives an interrupt output. The bus is synchronous to `clk`: an access is the one cycle in which `bus_cs` and `bus_stb` are both high. Read data is valid combinationally during that cycle. Writes and clear-on-read take effect at the closing clock edge.

On the core side the block takes a detection pulse with a 4-bit digit code, a pulse marking the end of a tone, and a pulse marking the end of a transmitted burst. Toward the tone generator it drives the digit to send, a tone enable, the call-progress mode, the single-tone controls and the burst enable. The read bus is modelled as data plus an output enable, and the data is forced to zero whenever the enable is low.

Top module: `tone_hif`

## Requirements
- R1: After reset, `tone_en`, `cp_mode`, `burst_en`, `single_tone`, `group_high` and `irq` are low, and a status read returns 0.
- R2: A write with `bus_rsel`=0 loads `bus_wdata` into the transmit register, seen on `tx_code` from the next cycle. A read with `bus_rsel`=0 returns the receive register.
- R3: The receive register takes `det_code` on every `det_valid` pulse and otherwise holds the last detected code.
- R4: A control write that reaches the first control register sets its fields from the data: bit 0 is tone enable (`tone_en`), bit 1 is call-progress mode (`cp_mode`), bit 2 is interrupt enable. Bit 3 is the steer bit of R5.
- R5: A control write to the first register with bit 3 set steers exactly the next control write to the second register. The control write after that goes to the first register again.
- R6: The second control register maps bit 0 to `burst_en`, bit 1 to `single_tone` and bit 2 to `group_high` (1 = high-group tone). Bit 3 is ignored.
- R7: A status read returns bit 0 = interrupt active, bit 1 = transmit ready, bit 2 = receive valid, bit 3 = tone ended. `det_valid` sets receive valid, `det_end` sets tone ended, and `tx_done` sets transmit ready while `burst_en` is high.
- R8: A status read returns the flags as they stood before the read, then clears all flags, so the status bits and `irq` read low afterwards.
- R9: `irq` is high exactly when interrupt enable is set and at least one flag is pending.
- R10: A detection, tone-end or burst-done event in the same cycle as a status read leaves its flag set after the read.
- R11: While `burst_en` is low, transmit ready is held clear.
- R12: `bus_rdata_oe` is high only during a read access. When it is low, `bus_rdata` is 0.
- R13: While `pwr_down` is high, `tone_en` is low. Power-down clears both control registers, the steering state and every status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Power-down, clears control and status |
| bus_cs | input | 1 | Chip select, active high |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_rsel | input | 1 | Register select |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, zero when not reading |
| bus_rdata_oe | output | 1 | Read data drive enable |
| irq | output | 1 | Interrupt request, active high |
| det_valid | input | 1 | Valid digit detected pulse |
| det_code | input | 4 | Code of the detected digit |
| det_end | input | 1 | Tone absence validated pulse |
| tx_done | input | 1 | Transmit burst finished pulse |
| tx_code | output | 4 | Digit to transmit |
| tone_en | output | 1 | Tone generator enable |
| cp_mode | output | 1 | Call-progress mode select |
| burst_en | output | 1 | Burst transmission enable |
| single_tone | output | 1 | Single-tone mode |
| group_high | output | 1 | Single tone taken from the high group |

## Verification
Two functions can land on the same clock edge here: the clearing of flags by a status read, and the setting of flags by core events. The bench provokes this by raising `det_valid`, `det_end` and `tx_done` in the very cycle in which the host reads status, for each event alone and all together. It then judges the result with a second status read, which must show every coincident flag still set while the first read showed the older value. The steering of control writes is exercised across the full value range of the second register, with a write to the first register after each one to show that the steering ended.

// File: rtl/tone_hif_pkg.sv
package tone_hif_pkg;
    localparam int NIB_W = 4;

    typedef struct packed {
        logic steer;
        logic irq_en;
        logic cp_mode;
        logic tone_en;
    } ctrl_a_t;

    typedef struct packed {
        logic spare;
        logic group_high;
        logic single_tone;
        logic burst_en;
    } ctrl_b_t;

    typedef struct packed {
        logic tone_gone;
        logic rx_valid;
        logic tx_ready;
        logic irq;
    } stat_t;
endpackage

// File: rtl/tone_hif_decode.sv
module tone_hif_decode (
    input  logic bus_cs,
    input  logic bus_stb,
    input  logic bus_rw,
    input  logic bus_rsel,
    output logic tx_wr,
    output logic ctrl_wr,
    output logic rx_rd,
    output logic st_rd,
    output logic rd_act
);
    logic acc;

    always_comb begin
        acc     = bus_cs && bus_stb;
        rd_act  = acc && bus_rw;
        tx_wr   = acc && !bus_rw && !bus_rsel;
        ctrl_wr = acc && !bus_rw && bus_rsel;
        rx_rd   = rd_act && !bus_rsel;
        st_rd   = rd_act && bus_rsel;
    end
endmodule

// File: rtl/tone_hif_ctrl.sv
module tone_hif_ctrl
    import tone_hif_pkg::*;
#(
    parameter int DW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] wdata,
    output ctrl_a_t       ctrl_a,
    output ctrl_b_t       ctrl_b
);
    typedef struct packed {
        ctrl_a_t a;
        ctrl_b_t b;
        logic    steer;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            if (st_q.steer) begin
                st_d.b       = ctrl_b_t'(wdata[NIB_W-1:0]);
                st_d.b.spare = 1'b0;
                st_d.steer   = 1'b0;
            end else begin
                st_d.a       = ctrl_a_t'(wdata[NIB_W-1:0]);
                st_d.a.steer = 1'b0;
                st_d.steer   = wdata[NIB_W-1];
            end
        end
        if (pwr_down) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_a = st_q.a;
    assign ctrl_b = st_q.b;

    // R5: steering lasts for one control write only
    p_steer_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.steer && ctrl_wr) |=> !st_q.steer);

    // R5: a steered write leaves the first register untouched
    p_steer_keeps_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.steer && ctrl_wr && !pwr_down) |=> $stable(st_q.a));

    // R13: power-down empties both control registers
    p_pdown_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (st_q == '0));
endmodule

// File: rtl/tone_hif_status.sv
module tone_hif_status
    import tone_hif_pkg::*;
#(
    parameter int CW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          st_rd,
    input  logic          det_valid,
    input  logic [CW-1:0] det_code,
    input  logic          det_end,
    input  logic          tx_done,
    input  logic          burst_en,
    input  logic          irq_en,
    output logic [CW-1:0] rx_code,
    output stat_t         stat,
    output logic          irq
);
    typedef struct packed {
        logic [CW-1:0] code;
        logic          rx_valid;
        logic          tone_gone;
        logic          tx_ready;
    } sstate_t;

    sstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_rd) begin
            st_d.rx_valid  = 1'b0;
            st_d.tone_gone = 1'b0;
            st_d.tx_ready  = 1'b0;
        end
        if (det_valid) begin
            st_d.code     = det_code;
            st_d.rx_valid = 1'b1;
        end
        if (det_end)             st_d.tone_gone = 1'b1;
        if (tx_done && burst_en) st_d.tx_ready  = 1'b1;
        if (!burst_en)           st_d.tx_ready  = 1'b0;
        if (pwr_down) begin
            st_d.rx_valid  = 1'b0;
            st_d.tone_gone = 1'b0;
            st_d.tx_ready  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        irq            = irq_en && (st_q.rx_valid || st_q.tone_gone || st_q.tx_ready);
        stat.irq       = irq;
        stat.tx_ready  = st_q.tx_ready;
        stat.rx_valid  = st_q.rx_valid;
        stat.tone_gone = st_q.tone_gone;
        rx_code        = st_q.code;
    end

    // R3: the receive register holds between detections
    p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !det_valid |=> $stable(st_q.code));

    // R8: a read with no new event leaves no flag set
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !det_valid && !det_end && !tx_done) |=> !irq && (stat == '0));

    // R10: a detection is never lost to a coincident read
    p_event_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && !pwr_down) |=> st_q.rx_valid);

    // R11: transmit ready stays clear without burst mode
    p_nb_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> !st_q.tx_ready);
endmodule

// File: rtl/tone_hif.sv
module tone_hif
    import tone_hif_pkg::*;
#(
    parameter int DW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          bus_cs,
    input  logic          bus_stb,
    input  logic          bus_rw,
    input  logic          bus_rsel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rdata_oe,
    output logic          irq,
    input  logic          det_valid,
    input  logic [DW-1:0] det_code,
    input  logic          det_end,
    input  logic          tx_done,
    output logic [DW-1:0] tx_code,
    output logic          tone_en,
    output logic          cp_mode,
    output logic          burst_en,
    output logic          single_tone,
    output logic          group_high
);
    logic          tx_wr, ctrl_wr, rx_rd, st_rd, rd_act;
    ctrl_a_t       ctrl_a;
    ctrl_b_t       ctrl_b;
    stat_t         stat;
    logic [DW-1:0] rx_code;
    logic [DW-1:0] txr_d, txr_q;

    tone_hif_decode u_dec (
        .bus_cs  (bus_cs),
        .bus_stb (bus_stb),
        .bus_rw  (bus_rw),
        .bus_rsel(bus_rsel),
        .tx_wr   (tx_wr),
        .ctrl_wr (ctrl_wr),
        .rx_rd   (rx_rd),
        .st_rd   (st_rd),
        .rd_act  (rd_act)
    );

    tone_hif_ctrl #(.DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_down(pwr_down),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .ctrl_a  (ctrl_a),
        .ctrl_b  (ctrl_b)
    );

    tone_hif_status #(.CW(DW)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .st_rd    (st_rd),
        .det_valid(det_valid),
        .det_code (det_code),
        .det_end  (det_end),
        .tx_done  (tx_done),
        .burst_en (ctrl_b.burst_en),
        .irq_en   (ctrl_a.irq_en),
        .rx_code  (rx_code),
        .stat     (stat),
        .irq      (irq)
    );

    always_comb begin
        txr_d = txr_q;
        if (tx_wr) txr_d = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txr_q <= '0;
        else        txr_q <= txr_d;
    end

    always_comb begin
        bus_rdata_oe = rd_act;
        bus_rdata    = '0;
        if (rx_rd)      bus_rdata = rx_code;
        else if (st_rd) bus_rdata = DW'(stat);
        tx_code     = txr_q;
        tone_en     = ctrl_a.tone_en && !pwr_down;
        cp_mode     = ctrl_a.cp_mode;
        burst_en    = ctrl_b.burst_en;
        single_tone = ctrl_b.single_tone;
        group_high  = ctrl_b.group_high;
    end

    // R9: the interrupt needs the enable held in the control block
    p_irq_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_a.irq_en);

    // R12: the bus is driven only while the host reads
    p_bus_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_stb && bus_rw) |-> !bus_rdata_oe && (bus_rdata == '0));

    // R13: no tone while powered down
    p_pdown_tone_r13: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !tone_en);

    // R2: a transmit write shows on the generator side next cycle
    p_tx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> (tx_code == $past(bus_wdata)));
endmodule

// File: tb/tone_hif_tb.sv
module tone_hif_tb;
    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       bus_cs = 1'b0, bus_stb = 1'b0, bus_rw = 1'b0, bus_rsel = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       bus_rdata_oe, irq;
    logic       det_valid = 1'b0, det_end = 1'b0, tx_done = 1'b0;
    logic [3:0] det_code = '0;
    logic [3:0] tx_code;
    logic       tone_en, cp_mode, burst_en, single_tone, group_high;

    int checks = 0;
    int fails  = 0;

    tone_hif u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .bus_cs(bus_cs), .bus_stb(bus_stb), .bus_rw(bus_rw), .bus_rsel(bus_rsel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .irq(irq), .det_valid(det_valid), .det_code(det_code), .det_end(det_end),
        .tx_done(tx_done), .tx_code(tx_code), .tone_en(tone_en), .cp_mode(cp_mode),
        .burst_en(burst_en), .single_tone(single_tone), .group_high(group_high)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic rs, input logic [3:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_stb = 1'b1; bus_rw = 1'b0; bus_rsel = rs; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_stb = 1'b0;
    endtask

    // read; optional core events raised in the same cycle
    task automatic rd(input logic rs, input logic [2:0] ev, input logic [3:0] code,
                      output logic [3:0] d, output logic oe);
        @(negedge clk);
        bus_cs = 1'b1; bus_stb = 1'b1; bus_rw = 1'b1; bus_rsel = rs;
        det_valid = ev[0]; det_end = ev[1]; tx_done = ev[2]; det_code = code;
        #1;
        d = bus_rdata; oe = bus_rdata_oe;
        @(negedge clk);
        bus_cs = 1'b0; bus_stb = 1'b0; bus_rw = 1'b0;
        det_valid = 1'b0; det_end = 1'b0; tx_done = 1'b0;
    endtask

    task automatic events(input logic [2:0] ev, input logic [3:0] code);
        @(negedge clk);
        det_valid = ev[0]; det_end = ev[1]; tx_done = ev[2]; det_code = code;
        @(negedge clk);
        det_valid = 1'b0; det_end = 1'b0; tx_done = 1'b0;
    endtask

    function automatic logic [3:0] stat_word(input logic ie, input logic rx,
                                             input logic tg, input logic tr);
        return {tg, rx, tr, ie && (rx || tg || tr)};
    endfunction

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] d;
        logic       oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs", {3'b0, tone_en, cp_mode, burst_en, single_tone, group_high}, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(1'b1, 3'b000, 4'h0, d, oe);
        check("R1 status", {4'h0, d}, 8'h00);

        // R12: idle bus and write cycle drive nothing
        #1 check("R12 idle", {3'b0, bus_rdata_oe, bus_rdata}, 8'h00);
        @(negedge clk);
        bus_cs = 1'b1; bus_stb = 1'b1; bus_rw = 1'b0; bus_rsel = 1'b0; bus_wdata = 4'h5;
        #1 check("R12 write", {3'b0, bus_rdata_oe, bus_rdata}, 8'h00);
        @(negedge clk);
        bus_cs = 1'b0; bus_stb = 1'b0;

        // R2: transmit register sweep
        for (int c = 0; c < 16; c++) begin
            wr(1'b0, 4'(c));
            check("R2 tx_code", {4'h0, tx_code}, 8'(c));
        end

        // R3/R2/R12: receive register sweep
        for (int c = 0; c < 16; c++) begin
            events(3'b001, 4'(15 - c));
            rd(1'b0, 3'b000, 4'h0, d, oe);
            check("R3 rx code", {4'h0, d}, 8'(15 - c));
            check("R12 read oe", {7'b0, oe}, 8'h01);
        end
        events(3'b000, 4'h9);
        rd(1'b0, 3'b000, 4'h0, d, oe);
        check("R3 hold", {4'h0, d}, 8'h00);

        // R4: first control register sweep
        for (int v = 0; v < 8; v++) begin
            wr(1'b1, 4'(v));
            check("R4 fields", {6'b0, tone_en, cp_mode}, {6'b0, v[0], v[1]});
        end

        // R5/R6: steered writes and return to first register
        for (int v = 0; v < 16; v++) begin
            wr(1'b1, 4'h8);
            wr(1'b1, 4'(v));
            check("R6 fields", {5'b0, group_high, single_tone, burst_en},
                  {5'b0, v[2], v[1], v[0]});
            check("R5 a untouched", {7'b0, tone_en}, 8'h00);
            wr(1'b1, 4'h1);
            check("R5 back to a", {6'b0, tone_en, burst_en}, {6'b0, 1'b1, v[0]});
        end

        // R7/R8/R9/R11: flag sweep over burst, interrupt enable and events
        for (int b = 0; b < 2; b++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int ev = 0; ev < 8; ev++) begin
                    logic rx, tg, tr;
                    wr(1'b1, 4'h8);
                    wr(1'b1, {3'b000, 1'(b)});
                    wr(1'b1, {1'b0, 1'(ie), 2'b00});
                    rd(1'b1, 3'b000, 4'h0, d, oe);
                    events(3'(ev), 4'h3);
                    rx = ev[0]; tg = ev[1]; tr = ev[2] && (b == 1);
                    check("R9 irq", {7'b0, irq}, {7'b0, (ie == 1) && (rx || tg || tr)});
                    rd(1'b1, 3'b000, 4'h0, d, oe);
                    check((ev[2] && b == 0) ? "R11 status" : "R7 status", {4'h0, d},
                          {4'h0, stat_word(ie == 1, rx, tg, tr)});
                    #1 check("R8 irq after read", {7'b0, irq}, 8'h00);
                    rd(1'b1, 3'b000, 4'h0, d, oe);
                    check("R8 status after read", {4'h0, d}, 8'h00);
                end
            end
        end

        // R10: events coincident with a status read
        wr(1'b1, 4'h8);
        wr(1'b1, 4'h1);
        wr(1'b1, 4'h4);
        for (int ev = 1; ev < 8; ev++) begin
            rd(1'b1, 3'b000, 4'h0, d, oe);
            events(3'b001, 4'h2);
            rd(1'b1, 3'(ev), 4'hA, d, oe);
            check("R10 old value", {4'h0, d}, {4'h0, stat_word(1'b1, 1'b1, 1'b0, 1'b0)});
            rd(1'b1, 3'b000, 4'h0, d, oe);
            check("R10 kept", {4'h0, d},
                  {4'h0, stat_word(1'b1, ev[0], ev[1], ev[2])});
        end
        rd(1'b0, 3'b000, 4'h0, d, oe);
        check("R10 code", {4'h0, d}, 8'h0A);

        // R13: power-down
        wr(1'b1, 4'h8);
        wr(1'b1, 4'h7);
        wr(1'b1, 4'hF);
        events(3'b111, 4'h6);
        @(negedge clk);
        pwr_down = 1'b1;
        #1 check("R13 tone low", {7'b0, tone_en}, 8'h00);
        @(negedge clk);
        pwr_down = 1'b0;
        check("R13 ctrl cleared", {3'b0, tone_en, cp_mode, burst_en, single_tone, group_high}, 8'h00);
        check("R13 irq", {7'b0, irq}, 8'h00);
        rd(1'b1, 3'b000, 4'h0, d, oe);
        check("R13 status", {4'h0, d}, 8'h00);
        wr(1'b1, 4'h1);
        check("R13 steer cleared", {6'b0, tone_en, burst_en}, 8'h02);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule